// File: doc/BRIEF.md
# Indirect Per-Channel Line Configuration Register Bank

This block holds the control and status bytes of an eight-channel line interface behind a byte-wide synchronous bus. The bus carries an address, write data, a write strobe, a read strobe and registered read data. Each channel has a private configuration byte. That byte is not mapped at its own address. Software first writes a channel number into a pointer register. It then reads or writes that channel's byte through one shared data window.

The configuration byte has two fields:
- a 4-bit line code, which sets the line impedance and pulse shape for both the receive and transmit paths;
- a 1-bit select for internal or external receive matching.

All eight line codes and matching selects are driven out continuously, one lane per channel, so each channel's pulse shaper and receiver front end can use them.

A directly mapped register holds one transmit high-impedance bit per channel. A sticky status register latches per-channel all-ones alarm reports from the receivers and raises an interrupt while any of its bits is set. Reading the status register clears it.

Top module: `chan_cfg_bank`

## Requirements
- R1: After reset, and again after a later reset, the following are all 0x00: every readable register, every channel's configuration byte, `tx_hiz`, `line_code`, `int_match` and `irq`.
- R2: A write to address 0x10 loads bits [2:0] of the write data into the channel pointer. A read of 0x10 returns the pointer in bits [2:0], with bits [7:3] as zero whatever was written to them.
- R3: A write to address 0x11 stores write-data bits [4:0] into the configuration byte of the channel named by the pointer. A read of 0x11 returns that byte, with bits [7:5] as zero.
- R4: For each channel n, `line_code[4n+3:4n]` equals bits [3:0] of its configuration byte and `int_match[n]` equals bit 4. Code 4'b0000 means the 120-ohm E1 shape and 4'b1000 means the 75-ohm E1 shape. Both codes are passed through unchanged.
- R5: A window write changes only the channel selected by the pointer. Every other channel's byte keeps its value.
- R6: A write to address 0x12 sets `tx_hiz` to the write data, so bit n drives channel n's transmit output to high impedance. A read of 0x12 returns the same byte.
- R7: A cycle with `alarm_in[n]` high sets status bit n from the next cycle on. The bit stays set after `alarm_in[n]` falls.
- R8: A read of address 0x13 returns the status byte as held before that cycle. It then clears every bit except those whose `alarm_in` bit is high in the read cycle.
- R9: `irq` is high exactly while at least one status bit is set.
- R10: A read of any address other than 0x10–0x13 returns 0x00. A write to any such address, or to 0x13, changes no register.
- R11: A pointer write takes effect for a window access in the very next cycle, with no wait cycle.
- R12: `rdata` changes only in the cycle after a read strobe, and otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| alarm_in | input | 8 | Per-channel all-ones alarm reports |
| irq | output | 1 | Interrupt, high while any status bit is set |
| tx_hiz | output | 8 | Per-channel transmit high-impedance enables |
| line_code | output | 32 | Per-channel 4-bit line codes, channel n in bits [4n+3:4n] |
| int_match | output | 8 | Per-channel internal receive matching selects |

## Verification
The bench builds the block with its defaults: eight channels, an 8-bit data path and 8-bit addresses. With these values every pointer value from 0 to 7 is reachable, and both reserved fields (pointer bits [7:3] and configuration bits [7:5]) can be written with ones and read back as zeros. The all-ones pointer write shows that the pointer truncates and does not wrap into a neighbouring channel. Status reads are placed against held, released and fresh alarms, so the read-clear race of R8 and the interrupt behaviour of R9 are both exercised.

// File: rtl/lcfg_pkg.sv
package lcfg_pkg;
    localparam int LEN_W = 4;
    localparam int CFG_W = LEN_W + 1;

    typedef struct packed {
        logic             int_match;
        logic [LEN_W-1:0] len;
    } chan_cfg_t;

    localparam logic [LEN_W-1:0] LEN_E1_120R = 4'b0000;
    localparam logic [LEN_W-1:0] LEN_E1_75R  = 4'b1000;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PTR,
        SEL_CFG,
        SEL_HIZ,
        SEL_ALM
    } reg_sel_e;
endpackage

// File: rtl/cfg_store.sv
module cfg_store
    import lcfg_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int PTR_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [PTR_W-1:0]        sel,
    input  logic [CFG_W-1:0]        wdata,
    output logic [NUM_CH*CFG_W-1:0] cfg_flat,
    output chan_cfg_t               rd_cfg
);
    chan_cfg_t mem_d [NUM_CH];
    chan_cfg_t mem_q [NUM_CH];
    logic      sel_ok;

    assign sel_ok = (32'(sel) < 32'(NUM_CH));

    always_comb begin
        mem_d = mem_q;
        if (we && sel_ok) begin
            mem_d[sel] = chan_cfg_t'(wdata);
        end
        rd_cfg = sel_ok ? mem_q[sel] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_flat
        assign cfg_flat[n*CFG_W +: CFG_W] = mem_q[n];
    end
endmodule

// File: rtl/alarm_latch.sv
module alarm_latch #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] alarm_in,
    input  logic              clr,
    output logic [NUM_CH-1:0] status
);
    logic [NUM_CH-1:0] status_d;
    logic [NUM_CH-1:0] status_q;

    always_comb begin
        status_d = (clr ? '0 : status_q) | alarm_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign status = status_q;
endmodule

// File: rtl/chan_cfg_bank.sv
module chan_cfg_bank
    import lcfg_pkg::*;
#(
    parameter int            NUM_CH   = 8,
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] ADDR_PTR = 8'h10,
    parameter logic [AW-1:0] ADDR_WIN = 8'h11,
    parameter logic [AW-1:0] ADDR_HIZ = 8'h12,
    parameter logic [AW-1:0] ADDR_ALM = 8'h13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           wdata,
    input  logic                    wr_en,
    input  logic                    rd_en,
    output logic [DW-1:0]           rdata,
    input  logic [NUM_CH-1:0]       alarm_in,
    output logic                    irq,
    output logic [NUM_CH-1:0]       tx_hiz,
    output logic [NUM_CH*LEN_W-1:0] line_code,
    output logic [NUM_CH-1:0]       int_match
);
    localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0]  ptr;
        logic [NUM_CH-1:0] hiz;
        logic [DW-1:0]     rdata;
    } bank_st_t;

    bank_st_t                st_d, st_q;
    reg_sel_e                sel;
    logic [DW-1:0]           rd_val;
    logic                    win_we;
    logic                    alm_clr;
    chan_cfg_t               rd_cfg;
    logic [NUM_CH*CFG_W-1:0] cfg_flat;
    logic [NUM_CH-1:0]       status;

    always_comb begin
        if      (addr == ADDR_PTR) sel = SEL_PTR;
        else if (addr == ADDR_WIN) sel = SEL_CFG;
        else if (addr == ADDR_HIZ) sel = SEL_HIZ;
        else if (addr == ADDR_ALM) sel = SEL_ALM;
        else                       sel = SEL_NONE;
    end

    assign win_we  = wr_en && (sel == SEL_CFG);
    assign alm_clr = rd_en && (sel == SEL_ALM);

    always_comb begin
        rd_val = '0;
        case (sel)
            SEL_PTR: rd_val[PTR_W-1:0]  = st_q.ptr;
            SEL_CFG: rd_val[CFG_W-1:0]  = rd_cfg;
            SEL_HIZ: rd_val[NUM_CH-1:0] = st_q.hiz;
            SEL_ALM: rd_val[NUM_CH-1:0] = status;
            default: rd_val = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && sel == SEL_PTR) st_d.ptr = wdata[PTR_W-1:0];
        if (wr_en && sel == SEL_HIZ) st_d.hiz = wdata[NUM_CH-1:0];
        if (rd_en)                   st_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    cfg_store #(.NUM_CH(NUM_CH), .PTR_W(PTR_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (win_we),
        .sel      (st_q.ptr),
        .wdata    (wdata[CFG_W-1:0]),
        .cfg_flat (cfg_flat),
        .rd_cfg   (rd_cfg)
    );

    alarm_latch #(.NUM_CH(NUM_CH)) u_alarm (
        .clk      (clk),
        .rst_n    (rst_n),
        .alarm_in (alarm_in),
        .clr      (alm_clr),
        .status   (status)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_lane
        assign line_code[n*LEN_W +: LEN_W] = cfg_flat[n*CFG_W +: LEN_W];
        assign int_match[n]                = cfg_flat[n*CFG_W + LEN_W];
    end

    assign irq    = |status;
    assign tx_hiz = st_q.hiz;
    assign rdata  = st_q.rdata;
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk #(
    parameter int            NUM_CH   = 8,
    parameter int            AW       = 8,
    parameter int            DW       = 8,
    parameter int            LEN_W    = 4,
    parameter logic [AW-1:0] ADDR_PTR = 8'h10,
    parameter logic [AW-1:0] ADDR_WIN = 8'h11,
    parameter logic [AW-1:0] ADDR_HIZ = 8'h12,
    parameter logic [AW-1:0] ADDR_ALM = 8'h13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [AW-1:0]           addr,
    input logic [DW-1:0]           wdata,
    input logic                    wr_en,
    input logic                    rd_en,
    input logic [DW-1:0]           rdata,
    input logic [NUM_CH-1:0]       alarm_in,
    input logic                    irq,
    input logic [NUM_CH-1:0]       tx_hiz,
    input logic [NUM_CH*LEN_W-1:0] line_code
);
    logic unmapped;
    assign unmapped = (addr != ADDR_PTR) && (addr != ADDR_WIN) &&
                      (addr != ADDR_HIZ) && (addr != ADDR_ALM);

    assert_hiz_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_HIZ) |=> (tx_hiz == $past(wdata[NUM_CH-1:0])));

    assert_alarm_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_in != '0) |=> irq);

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(rd_en && addr == ADDR_ALM)) |=> irq);

    assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_ALM && alarm_in == '0) |=> !irq);

    assert_unmapped_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && unmapped) |=> (rdata == '0));

    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && unmapped) |=> ($stable(tx_hiz) && $stable(line_code)));

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |=> $stable(rdata));
endmodule

bind chan_cfg_bank cfg_bank_chk #(
    .NUM_CH(NUM_CH), .AW(AW), .DW(DW), .LEN_W(lcfg_pkg::LEN_W),
    .ADDR_PTR(ADDR_PTR), .ADDR_WIN(ADDR_WIN), .ADDR_HIZ(ADDR_HIZ), .ADDR_ALM(ADDR_ALM)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .alarm_in(alarm_in), .irq(irq),
    .tx_hiz(tx_hiz), .line_code(line_code)
);

// File: tb/chan_cfg_bank_tb_top.sv
module chan_cfg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [7:0]  alarm_in = '0;
    logic        irq;
    logic [7:0]  tx_hiz;
    logic [31:0] line_code;
    logic [7:0]  int_match;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    chan_cfg_bank dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .alarm_in(alarm_in), .irq(irq),
        .tx_hiz(tx_hiz), .line_code(line_code), .int_match(int_match)
    );

    // Vector: {op[1:0], addr[7:0], data[7:0], expect[7:0]}; op 1 = write, 2 = read and compare
    localparam int NV = 21;
    localparam logic [25:0] VEC [NV] = '{
        {2'd1, 8'h10, 8'h03, 8'h00},  // R11 point at channel 3
        {2'd1, 8'h11, 8'h08, 8'h00},  // R11 window write in the next cycle, 75-ohm code
        {2'd2, 8'h11, 8'h00, 8'h08},  // R3
        {2'd1, 8'h10, 8'hFD, 8'h00},  // R2 upper bits dropped, channel 5
        {2'd1, 8'h11, 8'hFF, 8'h00},
        {2'd2, 8'h11, 8'h00, 8'h1F},  // R3 reserved bits read zero
        {2'd2, 8'h10, 8'h00, 8'h05},  // R2
        {2'd1, 8'h10, 8'hFF, 8'h00},
        {2'd2, 8'h10, 8'h00, 8'h07},  // R2 channel 7
        {2'd2, 8'h11, 8'h00, 8'h00},  // R5 channel 7 untouched
        {2'd1, 8'h10, 8'h03, 8'h00},
        {2'd2, 8'h11, 8'h00, 8'h08},  // R5 channel 3 kept
        {2'd1, 8'h12, 8'hA5, 8'h00},
        {2'd2, 8'h12, 8'h00, 8'hA5},  // R6
        {2'd1, 8'h20, 8'h55, 8'h00},  // R10 unmapped write
        {2'd2, 8'h20, 8'h00, 8'h00},  // R10 unmapped read
        {2'd2, 8'h14, 8'h00, 8'h00},  // R10
        {2'd1, 8'h10, 8'h05, 8'h00},
        {2'd2, 8'h11, 8'h00, 8'h1F},  // R5 channel 5 kept
        {2'd1, 8'h13, 8'hFF, 8'h00},  // R10 status not writable
        {2'd2, 8'h13, 8'h00, 8'h00}   // R10
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx_hiz", tx_hiz, 0);
        chk("R1 irq", irq, 0);
        chk("R1 line_code", line_code, 0);
        chk("R1 int_match", int_match, 0);
        for (int a = 8'h10; a <= 8'h13; a++) begin
            rd(8'(a), v);
            chk("R1 register", v, 0);
        end

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][25:24] == 2'd1) wr(VEC[i][23:16], VEC[i][15:8]);
            else begin
                rd(VEC[i][23:16], v);
                chk($sformatf("vector %0d (R2/R3/R5/R6/R10/R11 table)", i), v, VEC[i][7:0]);
            end
        end

        // R4 lanes: ch3 = 8 (75 ohm), ch5 = F with internal matching
        chk("R4 line_code", line_code, 32'h00F0_8000);
        chk("R4 int_match", int_match, 8'h20);
        chk("R6 tx_hiz port", tx_hiz, 8'hA5);
        wr(8'h10, 8'h00);
        wr(8'h11, 8'h10);
        chk("R4 120-ohm code with internal match", line_code[3:0], 4'b0000);
        chk("R4 int_match ch0", int_match, 8'h21);

        // R12 rdata holds without a read strobe
        rd(8'h12, v);
        wr(8'h12, 8'h3C);
        @(negedge clk);
        chk("R12 rdata hold", rdata, 8'hA5);
        chk("R6 tx_hiz rewrite", tx_hiz, 8'h3C);

        // R7, R9 alarm pulse latches
        alarm_in = 8'h21;
        @(negedge clk);
        alarm_in = 8'h00;
        @(negedge clk);
        chk("R9 irq after pulse", irq, 1);
        rd(8'h13, v);
        chk("R7 sticky status", v, 8'h21);
        chk("R8 irq cleared", irq, 0);
        rd(8'h13, v);
        chk("R8 status cleared", v, 8'h00);

        // R8 alarm held during the clearing read
        alarm_in = 8'h04;
        @(negedge clk);
        rd(8'h13, v);
        chk("R8 read value", v, 8'h04);
        alarm_in = 8'h00;
        chk("R8 held bit survives", irq, 1);
        rd(8'h13, v);
        chk("R8 held bit read", v, 8'h04);
        rd(8'h13, v);
        chk("R8 final clear", v, 8'h00);
        chk("R9 irq low", irq, 0);

        // R1 a second reset wipes everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 tx_hiz after reset", tx_hiz, 0);
        chk("R1 line_code after reset", line_code, 0);
        wr(8'h10, 8'h05);
        rd(8'h11, v);
        chk("R1 channel 5 after reset", v, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule